// File: doc/BRIEF.md
# 16-bit Time-Base Counter

This block is a free-running up-counting time base for a larger chip. A clock divider derives a count tick from the system clock. On each tick a 16-bit counter steps upward. When it has reached its top value, the counter falls back to zero and an update event occurs. Software can also ask for an update event at any time. At every update event the divider ratio and, when enabled, the top value are taken from their staged copies. The event also raises a sticky flag that drives an interrupt line.

Software reaches all state through one synchronous register port. A write takes effect at the clock edge where `reg_wr` is high. A read is combinational on `reg_addr`. The register map is: 0 control (bit 0 run, bit 1 top buffering, bit 2 flag mirror), 1 status (bit 0 update flag), 2 update request (bit 0), 3 counter, 4 divider staging, 5 top staging. Unmapped addresses read as zero.

Top module: `tbase16`

## Requirements
- R1: After reset, control reads 0, counter reads 0, divider staging reads 0, top staging reads 0xFFFF, and the flag and `upd_irq` are 0.
- R2: With run (control bit 0) set, the counter advances once every (active divider + 1) clocks. With run clear, neither the counter nor the divider moves.
- R3: The counter starts from 0 and counts up. A tick that finds it at or above the active top value returns it to 0 and causes an update event.
- R4: An update event sets the flag (status bit 0). Writing 0 to status bit 0 clears the flag, and writing 1 to it has no effect. If a clear and an update event fall in the same cycle, the flag ends up set.
- R5: A divider write only changes the staging value, which reads back at address 4. The active divider takes the staging value only at an update event.
- R6: With top buffering (control bit 1) set, a top write reaches the active top value only at an update event. With it clear, the write takes effect on the next cycle.
- R7: While the active top value is 0, ticks do not move the counter.
- R8: Writing 1 to update-request bit 0 causes an update event. It zeroes the counter and the divider phase, loads the staged values and sets the flag, and it takes priority over a tick in the same cycle.
- R9: A counter read gives the count in bits 15:0 and zeros in bits 30:16. Bit 31 carries the flag when mirror (control bit 2) is set and is 0 otherwise.
- R10: A write to address 3 loads the counter with data bits 15:0.
- R11: `upd_irq` always equals the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| upd_irq | output | 1 | Update interrupt, equal to the flag |

## Verification
Two collisions are forced. In the first, the bench issues a flag-clear write in exactly the cycle that its model predicts a wrapping tick; the flag must stay set. In the second, an update request lands on the same wrapping tick; the counter must come out at 0 and the flag must be set. A behavioural model runs next to the design, and every clock both the interrupt line and the readback of the selected address are compared with it.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_GEN   = 3'd2,
    A_COUNT = 3'd3,
    A_DIV   = 3'd4,
    A_TOP   = 3'd5
  } addr_e;

  localparam int B_RUN = 0;
  localparam int B_BUF = 1;
  localparam int B_MIR = 2;
  localparam int CTRL_W = 3;
endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt,
  input  logic          upd_evt,
  output logic          run,
  output logic          arr_buf,
  output logic          mirror,
  output logic          flag,
  output logic [CW-1:0] psc_pre,
  output logic [CW-1:0] arr_pre,
  output logic          ug,
  output logic          cnt_wr,
  output logic          arr_wr,
  output logic [DW-1:0] rdata
);
  localparam logic [CW-1:0] ARR_RST = '1;
  localparam int PAD = DW - CW;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q, flag_d;
  logic [CW-1:0]     psc_q, psc_d, arr_q, arr_d;
  logic              stat_clr;
  logic              wdata_hi_unused;

  assign wdata_hi_unused = ^wdata[DW-1:CW];

  assign ug       = wr && (addr == A_GEN) && wdata[0];
  assign cnt_wr   = wr && (addr == A_COUNT);
  assign arr_wr   = wr && (addr == A_TOP);
  assign stat_clr = wr && (addr == A_STAT) && !wdata[0];

  always_comb begin
    ctrl_d = ctrl_q;
    psc_d  = psc_q;
    arr_d  = arr_q;
    if (wr && addr == A_CTRL) ctrl_d = wdata[CTRL_W-1:0];
    if (wr && addr == A_DIV)  psc_d  = wdata[CW-1:0];
    if (arr_wr)               arr_d  = wdata[CW-1:0];
    if (upd_evt)       flag_d = 1'b1;
    else if (stat_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      psc_q  <= '0;
      arr_q  <= ARR_RST;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      psc_q  <= psc_d;
      arr_q  <= arr_d;
    end
  end

  assign run     = ctrl_q[B_RUN];
  assign arr_buf = ctrl_q[B_BUF];
  assign mirror  = ctrl_q[B_MIR];
  assign flag    = flag_q;
  assign psc_pre = psc_q;
  assign arr_pre = arr_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:  rdata = {{(DW-1){1'b0}}, flag_q};
      A_COUNT: rdata = {mirror & flag_q, {(PAD-1){1'b0}}, cnt};
      A_DIV:   rdata = {{PAD{1'b0}}, psc_q};
      A_TOP:   rdata = {{PAD{1'b0}}, arr_q};
      default: rdata = '0;
    endcase
  end

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> flag_q);
  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_clr) |=> flag_q);
endmodule

// File: rtl/tbase_presc.sv
module tbase_presc #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ug,
  input  logic          upd_evt,
  input  logic [CW-1:0] psc_pre,
  output logic          tick
);
  logic [CW-1:0] pc_q, pc_d, act_q, act_d;

  assign tick = run && (pc_q == act_q);

  always_comb begin
    if (ug)        pc_d = '0;
    else if (tick) pc_d = '0;
    else if (run)  pc_d = pc_q + 1'b1;
    else           pc_d = pc_q;
    act_d = upd_evt ? psc_pre : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      act_q <= '0;
    end else begin
      pc_q  <= pc_d;
      act_q <= act_d;
    end
  end

  assert_div_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(pc_q));
  assert_div_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(act_q));
  assert_ug_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (pc_q == '0));
endmodule

// File: rtl/tbase_count.sv
module tbase_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ug,
  input  logic          upd_evt,
  input  logic          cnt_wr,
  input  logic [CW-1:0] wval,
  input  logic          arr_buf,
  input  logic          arr_wr,
  input  logic [CW-1:0] arr_pre,
  output logic          ovf,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] ARR_RST = '1;

  logic [CW-1:0] cnt_q, cnt_d, arr_q, arr_d;
  logic          live;

  assign live = tick && (arr_q != '0);
  assign ovf  = live && (cnt_q >= arr_q);

  always_comb begin
    if (ug)          cnt_d = '0;
    else if (cnt_wr) cnt_d = wval;
    else if (ovf)    cnt_d = '0;
    else if (live)   cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;

    if (arr_wr && !arr_buf) arr_d = wval;
    else if (upd_evt)       arr_d = arr_pre;
    else                    arr_d = arr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arr_q <= ARR_RST;
    end else begin
      cnt_q <= cnt_d;
      arr_q <= arr_d;
    end
  end

  assign cnt = cnt_q;

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_q == '0 && !ug && !cnt_wr) |=> $stable(cnt_q));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_wr) |=> (cnt_q == '0));
  assert_ug_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt_q == '0));
  assert_top_buffered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_buf && !upd_evt) |=> $stable(arr_q));
endmodule

// File: rtl/tbase16.sv
module tbase16
  import tbase_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          upd_irq
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic core_rst_n;
  logic run, arr_buf, mirror, flag, ug, cnt_wr, arr_wr, tick, ovf, upd_evt;
  logic [CW-1:0] psc_pre, arr_pre, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rs_q[SYNC_STAGES-1];

  assign upd_evt = ug || ovf;
  assign upd_irq = flag;

  tbase_regs #(.CW(CW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(core_rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cnt(cnt), .upd_evt(upd_evt), .run(run),
    .arr_buf(arr_buf), .mirror(mirror), .flag(flag), .psc_pre(psc_pre),
    .arr_pre(arr_pre), .ug(ug), .cnt_wr(cnt_wr), .arr_wr(arr_wr),
    .rdata(reg_rdata)
  );

  tbase_presc #(.CW(CW)) presc_i (
    .clk(clk), .rst_n(core_rst_n), .run(run), .ug(ug),
    .upd_evt(upd_evt), .psc_pre(psc_pre), .tick(tick)
  );

  tbase_count #(.CW(CW)) count_i (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .ug(ug),
    .upd_evt(upd_evt), .cnt_wr(cnt_wr), .wval(reg_wdata[CW-1:0]),
    .arr_buf(arr_buf), .arr_wr(arr_wr), .arr_pre(arr_pre),
    .ovf(ovf), .cnt(cnt)
  );

  assert_mirror_off_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_addr == A_COUNT && !mirror) |-> !reg_rdata[DW-1]);
  assert_gap_zero_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_addr == A_COUNT) |-> (reg_rdata[DW-2:CW] == '0));
  assert_irq_flag_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_wr && reg_addr == A_GEN && reg_wdata[0]) |=> upd_irq);
endmodule

// File: tb/tbase16_tb_top.sv
module tbase16_tb_top;
  localparam int AC = 0, AS = 1, AG = 2, AN = 3, AD = 4, AT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        upd_irq;

  int tests = 0, fails = 0, cyc = 0;
  bit cmp_on = 1'b0;

  tbase16 dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                 .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_irq(upd_irq));

  always #2.5 clk = ~clk;

  // behavioural model
  int m_run, m_buf, m_mir, m_flag, m_cnt, m_pc, m_pp, m_pa, m_ap, m_aa;

  function automatic bit ovf_next();
    return m_run != 0 && m_pc == m_pa && m_aa != 0 && m_cnt >= m_aa;
  endfunction

  function automatic logic [31:0] m_read(int a);
    case (a)
      AC: return 32'(m_run + 2*m_buf + 4*m_mir);
      AS: return 32'(m_flag);
      AN: return {1'(m_mir != 0 && m_flag != 0), 15'd0, 16'(m_cnt)};
      AD: return 32'(m_pp);
      AT: return 32'(m_ap);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_buf = 0; m_mir = 0; m_flag = 0; m_cnt = 0; m_pc = 0;
      m_pp = 0; m_pa = 0; m_ap = 65535; m_aa = 65535;
    end else begin
      int a, d, ncnt, npc;
      bit ug, tk, ov, ev;
      a = int'(reg_addr); d = int'(reg_wdata);
      ug = reg_wr && a == AG && reg_wdata[0];
      tk = m_run != 0 && m_pc == m_pa;
      ov = ovf_next();
      ev = ug || ov;
      npc = ug ? 0 : (tk ? 0 : (m_run != 0 ? m_pc + 1 : m_pc));
      if (ug) ncnt = 0;
      else if (reg_wr && a == AN) ncnt = d & 16'hFFFF;
      else if (ov) ncnt = 0;
      else if (tk && m_aa != 0) ncnt = m_cnt + 1;
      else ncnt = m_cnt;
      if (reg_wr && a == AT && m_buf == 0) m_aa = d & 16'hFFFF;
      else if (ev) m_aa = m_ap;
      if (ev) m_pa = m_pp;
      if (ev) m_flag = 1;
      else if (reg_wr && a == AS && !reg_wdata[0]) m_flag = 0;
      if (reg_wr && a == AC) begin m_run = d & 1; m_buf = (d >> 1) & 1; m_mir = (d >> 2) & 1; end
      if (reg_wr && a == AD) m_pp = d & 16'hFFFF;
      if (reg_wr && a == AT) m_ap = d & 16'hFFFF;
      m_cnt = ncnt; m_pc = npc;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, before inputs move
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      check("R11 irq", 32'(upd_irq), 32'(m_flag));
      case (int'(reg_addr))
        AC: check("R1 control", reg_rdata, m_read(AC));
        AS: check("R4 status", reg_rdata, m_read(AS));
        AN: check("R9 counter", reg_rdata, m_read(AN));
        AD: check("R5 divider", reg_rdata, m_read(AD));
        AT: check("R6 top", reg_rdata, m_read(AT));
        default: check("R9 other", reg_rdata, 32'd0);
      endcase
    end
  end

  always @(negedge clk) if (cyc >= 100000) begin
    fails++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1 reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic sel(int a);
    @(negedge clk); #1 reg_addr = 3'(a);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int mx;
    bit seen;
    idle(5); #1 rst_n = 1'b1;
    idle(4); cmp_on = 1'b1;
    // R1 reset values
    sel(AC); @(negedge clk) check("R1 control reset", reg_rdata, 32'd0);
    sel(AN); @(negedge clk) check("R1 counter reset", reg_rdata, 32'd0);
    sel(AD); @(negedge clk) check("R1 divider reset", reg_rdata, 32'd0);
    sel(AT); @(negedge clk) check("R1 top reset", reg_rdata, 32'h0000FFFF);
    check("R1 irq reset", 32'(upd_irq), 32'd0);

    wr(AD, 2); wr(AT, 4); wr(AC, 1);
    idle(30);
    // R8 then R2: divide by three after update request
    wr(AG, 1); sel(AN);
    @(negedge clk) check("R8 counter zero after request", reg_rdata & 32'hFFFF, 32'd0);
    @(negedge clk) check("R2 first tick", reg_rdata & 32'hFFFF, 32'd1);
    idle(2);
    @(negedge clk) check("R2 second tick after 3 clocks", reg_rdata & 32'hFFFF, 32'd2);
    // R3 wraps at top 4
    mx = 0; seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (int'(reg_rdata[15:0]) > mx) mx = int'(reg_rdata[15:0]);
      if (mx == 4 && reg_rdata[15:0] == 16'd0) seen = 1;
    end
    check("R3 highest count", 32'(mx), 32'd4);
    check("R3 wrapped to zero", 32'(seen), 32'd1);

    // R4 clear, write-one ignored
    wr(AS, 0); check("R4 cleared", 32'(upd_irq), m_flag == 0 ? 32'd0 : 32'd1);
    wr(AC, 0); wr(AS, 0); wr(AS, 1); sel(AS);
    @(negedge clk) check("R4 write one no effect", reg_rdata, 32'd0);
    wr(AC, 1);
    // R4 collision: clear on the wrapping tick
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (ovf_next()) begin
        reg_wr = 1'b1; reg_addr = 3'(AS); reg_wdata = 32'd0;
        @(negedge clk); #1 reg_wr = 1'b0;
        break;
      end
    end
    @(negedge clk) check("R4 set wins over clear", 32'(upd_irq), 32'd1);
    // R8 collision: request on the wrapping tick
    sel(AN);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (ovf_next()) begin
        reg_wr = 1'b1; reg_addr = 3'(AG); reg_wdata = 32'd1;
        @(negedge clk); #1 reg_wr = 1'b0; reg_addr = 3'(AN);
        break;
      end
    end
    @(negedge clk) check("R8 request on wrap", reg_rdata & 32'hFFFF, 32'd0);

    // R7 stall and R10 load
    wr(AT, 0); sel(AN); @(negedge clk) v = reg_rdata;
    idle(30); @(negedge clk) check("R7 stalled counter", reg_rdata, v);
    wr(AN, 3); sel(AN); idle(5);
    @(negedge clk) check("R10 counter load", reg_rdata & 32'hFFFF, 32'd3);
    // R6 immediate then buffered
    wr(AT, 10); wr(AC, 3); wr(AT, 6); sel(AN);
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); if (reg_rdata[15:0] > 16'd6) seen = 1;
    end
    check("R6 buffered top deferred", 32'(seen), 32'd1);
    wr(AG, 1); sel(AN); mx = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (int'(reg_rdata[15:0]) > mx) mx = int'(reg_rdata[15:0]);
    end
    check("R6 new top after update", 32'(mx), 32'd6);
    // R9 mirror
    wr(AC, 7); sel(AN); idle(2);
    @(negedge clk) check("R9 bit31 mirrors flag", 32'(reg_rdata[31]), 32'd1);
    wr(AC, 3); sel(AN);
    @(negedge clk) check("R9 bit31 clear without mirror", 32'(reg_rdata[31]), 32'd0);
    // R2 freeze
    wr(AC, 0); sel(AN); @(negedge clk) v = reg_rdata;
    idle(25); @(negedge clk) check("R2 frozen without run", reg_rdata, v);

    idle(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule